// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block is the sample buffer for one direction of one serial audio port. A processor reaches it through three word registers: a data register, a control register and a status register. The serial engine reaches it through a one-cycle pop strobe (playback build) or push strobe (capture build). The direction is fixed by a parameter. In the playback build the processor writes samples and the serial side pops them. In the capture build the serial side pushes samples and the processor reads them.

The usable depth depends on a RAM size code and on the channel count. The channel count is rounded up to a power of two before the words are split among channels, so odd channel counts leave part of the RAM unused. Fill level is counted in whole frames, where one frame is one sample per channel. The status register also holds sticky overrun and underrun flags. The control register holds a half-level interrupt enable and a FIFO clear that clears itself.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty, the status register reads 0, the control register reads 0 and `half_irq` is low.
- R2: A word is stored as its low 24 bits only. Stored words leave the FIFO in the order they entered. The head word is shown combinationally on the read side.
- R3: Frame capacity is (256 << min(ram_code, MAX_CODE)) >> k, where k is the smallest value with 2^k >= channel count; channel count 0 is treated as 1 and values above 8 as 8. Word capacity is frame capacity times channel count. A store while the FIFO holds the word capacity is dropped and sets the overrun flag, status bit 4.
- R4: A pop from an empty FIFO returns 0 and sets the underrun flag, status bit 0.
- R5: Status bits 16:8 hold the fill level. It is the number of complete frames stored minus the number of complete frames consumed, and it is updated one clock after the operation.
- R6: A write to the status register clears each flag whose bit in the written value is 0. A set event in the same cycle wins over the clear.
- R7: Writing control bit 0 empties the FIFO at that clock edge and leaves both flags as they were. Control bit 0 always reads back as 0.
- R8: In the playback build, `half_irq` is high when control bit 20 is set and the fill level is at or below half the frame capacity.
- R9: In the capture build, `half_irq` is high when control bit 20 is set and the fill level is at or above half the frame capacity. A processor read of the data register pops one word.
- R10: With `narrow_mode` high, a processor data write stores `cpu_wdata[15:0]` shifted left by 8. A processor data read returns the stored word shifted right by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_code | input | 3 | RAM size code |
| chan_cnt | input | 4 | Channels per frame, 1 to 8 |
| narrow_mode | input | 1 | 16-bit left-justified samples on the processor side |
| cpu_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, combinational |
| ser_pop | input | 1 | Serial side takes a word (playback build) |
| ser_pop_data | output | 24 | Head word for the serial side, 0 when empty |
| ser_push | input | 1 | Serial side offers a word (capture build) |
| ser_push_data | input | 24 | Word offered by the serial side |
| half_irq | output | 1 | Half-level interrupt |

## Verification
Read data and `ser_pop_data` are combinational from the head pointer, so the bench checks them in the same cycle as the strobe, one nanosecond after it drives inputs on the falling edge. Fill level, flags, control readback and `half_irq` come from registers, so they are due one rising edge after the operation that moves them. The bench reads them only in a later cycle, after that edge has passed. Every stimulus is applied on a falling edge, which keeps each expected value tied to exactly one rising edge.

// File: rtl/asf_pkg.sv
// Shared constants for the audio sample FIFO: register map, bit positions
// and the base RAM size. Assumes 2-bit word addressing on the processor port.
package asf_pkg;
    localparam int          BASE_WORDS = 256;
    localparam int          SAMPLE_W   = 24;
    localparam logic [1:0]  ADDR_DATA  = 2'd0;
    localparam logic [1:0]  ADDR_CTRL  = 2'd1;
    localparam logic [1:0]  ADDR_STAT  = 2'd2;
    localparam int          BIT_CLR    = 0;
    localparam int          BIT_IRQEN  = 20;
    localparam int          BIT_OVR    = 4;
    localparam int          BIT_UND    = 0;
    localparam int          FILL_LO    = 8;
    localparam int          FILL_W     = 9;

    // Clamp a channel count into 1..8.
    function automatic logic [3:0] clamp_chan(input logic [3:0] c);
        if (c == 4'd0)      return 4'd1;
        else if (c > 4'd8)  return 4'd8;
        else                return c;
    endfunction
endpackage

// File: rtl/asf_capacity.sv
// Derives frame capacity, word capacity and half level from the size code
// and the channel count. Purely combinational; assumes MAX_CODE keeps the
// physical RAM at 256 << MAX_CODE words.
module asf_capacity
    import asf_pkg::*;
#(
    parameter int MAX_CODE = 0,
    parameter int AW       = 9
) (
    input  logic [2:0]    ram_code,
    input  logic [3:0]    chan_in,
    output logic [3:0]    chan_eff,
    output logic [AW-1:0] cap_frames,
    output logic [AW-1:0] cap_words,
    output logic [AW-1:0] half_frames
);
    logic [2:0] code_c;
    logic [1:0] shift;

    // Clamp inputs and find the power-of-two rounding shift.
    always_comb begin
        chan_eff = clamp_chan(chan_in);
        code_c   = (ram_code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : ram_code;
        if (chan_eff <= 4'd1)      shift = 2'd0;
        else if (chan_eff <= 4'd2) shift = 2'd1;
        else if (chan_eff <= 4'd4) shift = 2'd2;
        else                       shift = 2'd3;
    end

    // Scale the base RAM and split it among the rounded channel count.
    always_comb begin
        cap_frames  = (AW'(BASE_WORDS) << code_c) >> shift;
        cap_words   = cap_frames * AW'(chan_eff);
        half_frames = cap_frames >> 1;
    end
endmodule

// File: rtl/asf_ram.sv
// Sample storage: one synchronous write port, one asynchronous read port.
// No reset on contents; the pointers define what is valid.
module asf_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 24,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/asf_frame_count.sv
// Counts complete frames passing one side of the FIFO. A frame completes
// when the channel position wraps. Assumes chan is already clamped to 1..8.
module asf_frame_count #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [3:0]    chan,
    output logic [AW-1:0] frames
);
    logic [2:0] pos;

    // Advance the channel position and count wraps as frames.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos    <= '0;
            frames <= '0;
        end else if (step) begin
            if (4'(pos) + 4'd1 >= chan) begin
                pos    <= '0;
                frames <= frames + 1'b1;
            end else begin
                pos <= pos + 3'd1;
            end
        end
    end
endmodule

// File: rtl/audio_sample_fifo.sv
// Channel-aware sample FIFO for one direction of a serial audio port.
// IS_OUTPUT=1: processor writes, serial side pops. IS_OUTPUT=0: serial side
// pushes, processor reads. Assumes ram_code and chan_cnt stay fixed while
// data is in flight; clear the FIFO after changing them.
module audio_sample_fifo
    import asf_pkg::*;
#(
    parameter int IS_OUTPUT = 1,
    parameter int MAX_CODE  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  ram_code,
    input  logic [3:0]  chan_cnt,
    input  logic        narrow_mode,
    input  logic [1:0]  cpu_addr,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    input  logic        ser_pop,
    output logic [23:0] ser_pop_data,
    input  logic        ser_push,
    input  logic [23:0] ser_push_data,
    output logic        half_irq
);
    localparam int DEPTH = BASE_WORDS << MAX_CODE;
    localparam int IW    = $clog2(DEPTH);
    localparam int AW    = IW + 1;

    logic [3:0]          chan_eff;
    logic [AW-1:0]       cap_frames, cap_words, half_frames;
    logic [AW-1:0]       wr_ptr, rd_ptr, count_words;
    logic [AW-1:0]       wr_frames, rd_frames, fill;
    logic                wr_req, rd_req, full, empty, wr_ok, rd_ok;
    logic                clr_req, st_wr, ctrl_wr;
    logic                irq_en, ovr_q, und_q;
    logic [SAMPLE_W-1:0] wr_word, ram_q, head;
    logic [31:0]         data_rd_val;

    asf_capacity #(.MAX_CODE(MAX_CODE), .AW(AW)) u_cap (
        .ram_code    (ram_code),
        .chan_in     (chan_cnt),
        .chan_eff    (chan_eff),
        .cap_frames  (cap_frames),
        .cap_words   (cap_words),
        .half_frames (half_frames)
    );

    // Register decode for the processor port.
    assign ctrl_wr = cpu_wr && (cpu_addr == ADDR_CTRL);
    assign clr_req = ctrl_wr && cpu_wdata[BIT_CLR];
    assign st_wr   = cpu_wr && (cpu_addr == ADDR_STAT);

    // Direction-specific request sources, store data and read data.
    generate
        if (IS_OUTPUT != 0) begin : g_out
            assign wr_req      = cpu_wr && (cpu_addr == ADDR_DATA);
            assign rd_req      = ser_pop;
            assign wr_word     = narrow_mode ? {cpu_wdata[15:0], 8'h00}
                                             : cpu_wdata[SAMPLE_W-1:0];
            assign ser_pop_data = head;
            assign data_rd_val = 32'h0;
        end else begin : g_in
            assign wr_req      = ser_push;
            assign rd_req      = cpu_rd && (cpu_addr == ADDR_DATA);
            assign wr_word     = ser_push_data;
            assign ser_pop_data = '0;
            assign data_rd_val = narrow_mode ? {16'h0, head[23:8]}
                                             : {8'h0, head};
        end
    endgenerate

    // Occupancy and acceptance.
    assign count_words = wr_ptr - rd_ptr;
    assign full        = count_words >= cap_words;
    assign empty       = (count_words == '0);
    assign wr_ok       = wr_req && !full;
    assign rd_ok       = rd_req && !empty;
    assign head        = empty ? '0 : ram_q;

    asf_ram #(.DEPTH(DEPTH), .DW(SAMPLE_W), .IW(IW)) u_ram (
        .clk   (clk),
        .we    (wr_ok && !clr_req),
        .waddr (wr_ptr[IW-1:0]),
        .wdata (wr_word),
        .raddr (rd_ptr[IW-1:0]),
        .rdata (ram_q)
    );

    // Word pointers; a clear wins over any transfer in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    asf_frame_count #(.AW(AW)) u_wr_frames (
        .clk (clk), .rst_n (rst_n), .clr (clr_req),
        .step (wr_ok), .chan (chan_eff), .frames (wr_frames)
    );

    asf_frame_count #(.AW(AW)) u_rd_frames (
        .clk (clk), .rst_n (rst_n), .clr (clr_req),
        .step (rd_ok), .chan (chan_eff), .frames (rd_frames)
    );

    assign fill = wr_frames - rd_frames;

    // Sticky error flags: status write clears zero bits, new events set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            ovr_q <= (ovr_q && !(st_wr && !cpu_wdata[BIT_OVR])) || (wr_req && full && !clr_req);
            und_q <= (und_q && !(st_wr && !cpu_wdata[BIT_UND])) || (rd_req && empty && !clr_req);
        end
    end

    // Interrupt enable held in the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_en <= 1'b0;
        else if (ctrl_wr) irq_en <= cpu_wdata[BIT_IRQEN];
    end

    // Half-level comparison picks its sense from the direction.
    generate
        if (IS_OUTPUT != 0) begin : g_irq_out
            assign half_irq = irq_en && (fill <= half_frames);
        end else begin : g_irq_in
            assign half_irq = irq_en && (fill >= half_frames);
        end
    endgenerate

    // Processor read mux.
    always_comb begin
        cpu_rdata = 32'h0;
        case (cpu_addr)
            ADDR_DATA: cpu_rdata = data_rd_val;
            ADDR_CTRL: cpu_rdata[BIT_IRQEN] = irq_en;
            ADDR_STAT: begin
                cpu_rdata[FILL_LO +: FILL_W] = fill[FILL_W-1:0];
                cpu_rdata[BIT_OVR]           = ovr_q;
                cpu_rdata[BIT_UND]           = und_q;
            end
            default:   cpu_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/audio_sample_fifo_chk.sv
// Assertion checker bound into every audio_sample_fifo instance.
module audio_sample_fifo_chk #(
    parameter int AW        = 9,
    parameter int IS_OUTPUT = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic          rd_req,
    input logic          full,
    input logic          empty,
    input logic          clr_req,
    input logic          st_wr,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic          ovr_q,
    input logic          und_q,
    input logic          irq_en,
    input logic          half_irq,
    input logic [23:0]   ser_pop_data
);
    // R3: a store into a full FIFO leaves the write pointer where it was
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !clr_req) |=> $stable(wr_ptr));

    // R3: a dropped store raises overrun
    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !clr_req) |=> ovr_q);

    // R4: a pop from empty raises underrun
    p_underrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty && !clr_req) |=> und_q);

    // R4: the serial side sees zero while empty
    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_OUTPUT != 0 && empty) |-> (ser_pop_data == 24'h0));

    // R6: flags hold without a status write
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !st_wr) |=> ovr_q);

    // R7: a clear leaves the FIFO empty
    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (wr_ptr == rd_ptr));

    // R8: no interrupt without enable
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq |-> irq_en);
endmodule

bind audio_sample_fifo audio_sample_fifo_chk #(.AW(AW), .IS_OUTPUT(IS_OUTPUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_req       (wr_req),
    .rd_req       (rd_req),
    .full         (full),
    .empty        (empty),
    .clr_req      (clr_req),
    .st_wr        (st_wr),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .ovr_q        (ovr_q),
    .und_q        (und_q),
    .irq_en       (irq_en),
    .half_irq     (half_irq),
    .ser_pop_data (ser_pop_data)
);

// File: tb/audio_sample_fifo_tb.sv
module audio_sample_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ram_code = 3'd0;
    logic [3:0]  chan_cnt = 4'd2;
    logic        narrow_mode = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [31:0] cpu_wdata = 32'h0;
    logic [31:0] cpu_rdata;
    logic        ser_pop = 1'b0;
    logic [23:0] ser_pop_data;
    logic        half_irq;

    // capture-direction instance
    logic [3:0]  chan_i = 4'd1;
    logic        narrow_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic        wr_i = 1'b0, rd_i = 1'b0;
    logic [31:0] wdata_i = 32'h0;
    logic [31:0] rdata_i;
    logic [23:0] pop_data_i;
    logic        push_i = 1'b0;
    logic [23:0] push_data_i = 24'h0;
    logic        irq_i;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    audio_sample_fifo #(.IS_OUTPUT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ram_code(ram_code), .chan_cnt(chan_cnt),
        .narrow_mode(narrow_mode), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ser_pop(ser_pop), .ser_pop_data(ser_pop_data), .ser_push(1'b0),
        .ser_push_data(24'h0), .half_irq(half_irq)
    );

    audio_sample_fifo #(.IS_OUTPUT(0)) u_dut_in (
        .clk(clk), .rst_n(rst_n), .ram_code(3'd0), .chan_cnt(chan_i),
        .narrow_mode(narrow_i), .cpu_addr(addr_i), .cpu_wr(wr_i),
        .cpu_rd(rd_i), .cpu_wdata(wdata_i), .cpu_rdata(rdata_i),
        .ser_pop(1'b0), .ser_pop_data(pop_data_i), .ser_push(push_i),
        .ser_push_data(push_data_i), .half_irq(irq_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-CHECK FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_wr = 0; cpu_rd = 0; ser_pop = 0; wr_i = 0; rd_i = 0; push_i = 0;
    endtask

    task automatic cwr(input logic [1:0] a, input logic [31:0] d);
        idle();
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    endtask

    task automatic crd(input logic [1:0] a, input logic [31:0] exp, input string req);
        idle();
        cpu_addr = a; cpu_rd = 1;
        #1 chk(req, cpu_rdata, exp);
    endtask

    task automatic spop(input logic [31:0] exp, input string req);
        idle();
        ser_pop = 1;
        #1 chk(req, {8'h0, ser_pop_data}, exp);
    endtask

    // op: 0 cpu write, 1 cpu read check, 2 serial pop check
    localparam int NV = 12;
    localparam logic [67:0] VEC [NV] = '{
        {2'd1, 2'd2, 32'h0,        32'h0},        // R1 status after reset
        {2'd0, 2'd0, 32'hAB123456, 32'h0},        // R2 upper byte discarded
        {2'd0, 2'd0, 32'h00654321, 32'h0},
        {2'd1, 2'd2, 32'h0,        32'h00000100}, // R5 one frame stored
        {2'd2, 2'd0, 32'h0,        32'h00123456}, // R2 first in, first out
        {2'd1, 2'd2, 32'h0,        32'h00000100}, // R5 half-consumed frame still counts
        {2'd2, 2'd0, 32'h0,        32'h00654321}, // R2
        {2'd1, 2'd2, 32'h0,        32'h0},        // R5 empty
        {2'd2, 2'd0, 32'h0,        32'h0},        // R4 pop when empty returns 0
        {2'd1, 2'd2, 32'h0,        32'h00000001}, // R4 underrun bit 0
        {2'd0, 2'd2, 32'h0,        32'h0},        // R6 clear flags
        {2'd1, 2'd2, 32'h0,        32'h0}         // R6 flags gone
    };

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FIFO-CHECK FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        #1 chk("R1 irq low", {31'h0, half_irq}, 32'h0);
        crd(2'd1, 32'h0, "R1 ctrl");

        for (int i = 0; i < NV; i++) begin
            logic [67:0] v;
            v = VEC[i];
            case (v[67:66])
                2'd0: cwr(v[65:64], v[63:32]);
                2'd1: crd(v[65:64], v[31:0], $sformatf("R1/R5/R6 vec%0d", i));
                default: spop(v[31:0], $sformatf("R2/R4 vec%0d", i));
            endcase
        end

        // R8: playback half level, 2 channels, 128 frames, half 64
        cwr(2'd1, 32'h00100000);
        idle();
        #1 chk("R8 irq at fill 0", {31'h0, half_irq}, 32'h1);
        crd(2'd1, 32'h00100000, "R8 ctrl readback");
        for (int i = 0; i < 128; i++) cwr(2'd0, i);
        idle();
        #1 chk("R8 irq at fill 64", {31'h0, half_irq}, 32'h1);
        cwr(2'd0, 32'h1); cwr(2'd0, 32'h2);
        idle();
        #1 chk("R8 irq at fill 65", {31'h0, half_irq}, 32'h0);
        crd(2'd2, 32'h00004100, "R5 fill 65");

        // R3: 3 channels use 4-channel units: 64 frames, 192 words
        cwr(2'd1, 32'h1);
        chan_cnt = 4'd3;
        for (int i = 0; i < 200; i++) cwr(2'd0, i);
        crd(2'd2, 32'h00004010, "R3 3ch cap 64 and overrun");

        // R7: clear empties FIFO, keeps overrun
        cwr(2'd1, 32'h1);
        crd(2'd2, 32'h00000010, "R7 clear keeps flag");
        crd(2'd1, 32'h0, "R7 clear bit reads 0");

        // R3: 5 channels -> 32 frames
        chan_cnt = 4'd5;
        for (int i = 0; i < 170; i++) cwr(2'd0, i);
        crd(2'd2, 32'h00002010, "R3 5ch cap 32");
        cwr(2'd2, 32'h0);
        crd(2'd2, 32'h00002000, "R6 clear with fill kept");

        // R3: 1 channel -> 256 frames, 257th write overruns
        cwr(2'd1, 32'h1);
        chan_cnt = 4'd1;
        for (int i = 0; i < 257; i++) cwr(2'd0, i);
        crd(2'd2, 32'h00010010, "R3 1ch cap 256");

        // R10: narrow playback
        cwr(2'd1, 32'h1);
        cwr(2'd2, 32'h0);
        narrow_mode = 1;
        cwr(2'd0, 32'hFFFF1234);
        spop(32'h00123400, "R10 narrow store");
        narrow_mode = 0;

        // R9: capture direction, 1 channel, 256 frames, half 128
        idle(); addr_i = 2'd1; wdata_i = 32'h00100000; wr_i = 1;
        idle(); push_i = 1; push_data_i = 24'h5A5A00;
        for (int i = 1; i < 127; i++) begin
            idle(); push_i = 1; push_data_i = 24'(i + 1);
        end
        idle();
        #1 chk("R9 irq at fill 127", {31'h0, irq_i}, 32'h0);
        push_i = 1; push_data_i = 24'h0000AA;
        idle();
        #1 chk("R9 irq at fill 128", {31'h0, irq_i}, 32'h1);
        narrow_i = 1; addr_i = 2'd0; rd_i = 1;
        #1 chk("R10 narrow readback", rdata_i, 32'h00005A5A);
        idle(); narrow_i = 0; addr_i = 2'd0; rd_i = 1;
        #1 chk("R9 cpu read pops", rdata_i, 32'h00000002);
        idle(); addr_i = 2'd2; rd_i = 1;
        #1 chk("R9 fill after pops", rdata_i, 32'h00007E00);
        #1 chk("R9 irq below half", {31'h0, irq_i}, 32'h0);

        // R1 again: reset mid-run returns to empty
        idle();
        rst_n = 0;
        idle();
        rst_n = 1;
        crd(2'd2, 32'h0, "R1 status after second reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule